// File: doc/BRIEF.md
# Programmable PLL post-divider bank

This block sits after a fast VCO clock and produces three clocks from it: a bit clock, a byte clock and a pixel clock. Each one comes from its own integer divider. Each divider is programmed through a field that stores the divide ratio minus one. The byte and pixel fields are loaded directly from a write bus. The byte field can also be filled by a rate helper. The helper takes a requested serial bit rate in MHz and picks a byte divide factor from a fixed threshold table.

The bit divider is not written by software. It is derived from the byte divider, as the byte ratio over eight, so the bit clock runs eight times faster than the byte clock. Each divider picks up a new ratio only when its current period ends. The enable input stops all three outputs, holds them low and parks the counters.

Top module: `pll_postdiv_bank`

## Requirements
- R1: Each output divides the VCO clock by its field value plus one. The outputs are bit (`bit_clk`, field `bit_field`), byte (`byte_clk`, field `byte_field`) and pixel (`pix_clk`, field `pix_field`).
- R2: Writes and readback:
  - A `wr_byte` pulse loads `wdata` into `byte_field` at that clock edge. A `wr_pix` pulse loads `wdata` into `pix_field` at that clock edge.
  - When `wr_rate` and `wr_byte` are both high, `wr_rate` wins.
  - A field with no write strobe holds its value.
- R3: After reset, `byte_field` is 7 (ratio 8), `pix_field` is 3 (ratio 4) and `bit_field` is 0.
- R4: A `wr_rate` pulse loads `byte_field` from `bit_mhz`:
  - 63 (factor 64) below 125.
  - 31 (factor 32) from 125 to below 250.
  - 15 (factor 16) from 250 to below 600.
  - 7 (factor 8) for 600 and above.
- R5: `bit_field` (4 bits) follows the byte field at all times:
  - It is (byte ratio / 8) − 1, where byte ratio = `byte_field`+1 and the division truncates.
  - A quotient of 0 gives 0.
  - A quotient above 16 gives 15.
- R6: For a ratio R ≥ 2, the output is high for (R+1)/2 VCO cycles (integer division) and low for the rest of the period. Even ratios give a 50% duty cycle; odd ratios are high one cycle longer than low.
- R7: A field value of 0 passes the VCO clock to that output unchanged while the block is enabled.
- R8: A new field value takes effect only when the divider's current period ends. The period that is running when the write arrives completes with the old high and low lengths.
- R9: Enable behaviour:
  - While `en` is low, all three outputs are low.
  - After `en` rises, each output with a ratio of 2 or more goes high at the first VCO edge that samples `en` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast VCO clock that all dividers count |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Divider run enable, synchronous to clk_vco |
| wr_byte | input | 1 | Load wdata into the byte field |
| wr_pix | input | 1 | Load wdata into the pixel field |
| wr_rate | input | 1 | Load the byte field from the rate table using bit_mhz |
| wdata | input | 8 | Field value (ratio minus one) for wr_byte and wr_pix |
| bit_mhz | input | 12 | Requested bit rate in MHz for the rate helper |
| byte_field | output | 8 | Current byte divider field |
| pix_field | output | 8 | Current pixel divider field |
| bit_field | output | 4 | Derived bit divider field |
| bit_clk | output | 1 | Divided bit clock |
| byte_clk | output | 1 | Divided byte clock |
| pix_clk | output | 1 | Divided pixel clock |

## Verification
The properties take for granted the following about the inputs:
- `en`, `wr_byte`, `wr_pix`, `wr_rate`, `wdata` and `bit_mhz` are synchronous to `clk_vco`.
- `wdata` and `bit_mhz` are valid in the cycle their strobe is high.

The stimulus changes every input just after a falling VCO edge and holds each strobe for exactly one cycle. It waits longer than the largest old period before measuring a newly written ratio.

// File: rtl/pll_postdiv_bank.sv
module pll_postdiv_bank #(
  parameter int FW     = 8,
  parameter int BW     = 4,
  parameter int RW     = 12,
  parameter int T_SLOW = 125,
  parameter int T_MID  = 250,
  parameter int T_FAST = 600
) (
  input  logic          clk_vco,
  input  logic          rst_n,
  input  logic          en,
  input  logic          wr_byte,
  input  logic          wr_pix,
  input  logic          wr_rate,
  input  logic [FW-1:0] wdata,
  input  logic [RW-1:0] bit_mhz,
  output logic [FW-1:0] byte_field,
  output logic [FW-1:0] pix_field,
  output logic [BW-1:0] bit_field,
  output logic          bit_clk,
  output logic          byte_clk,
  output logic          pix_clk
);
  localparam int NDIV = 3;
  localparam logic [FW:0] BIT_MAX = (FW+1)'(1 << BW);

  logic [FW-1:0] byte_q, pix_q, rate_code;
  logic [FW:0]   byte_ratio, bit_ratio;
  logic [BW-1:0] bit_q;
  logic          run;
  logic [FW-1:0] fld [NDIV];
  logic [NDIV-1:0] dout;

  always_comb begin
    if (bit_mhz < RW'(T_SLOW))     rate_code = FW'(63);
    else if (bit_mhz < RW'(T_MID)) rate_code = FW'(31);
    else if (bit_mhz < RW'(T_FAST)) rate_code = FW'(15);
    else                           rate_code = FW'(7);
  end

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= FW'(7);
      pix_q  <= FW'(3);
      run    <= 1'b0;
    end else begin
      run <= en;
      if (wr_rate)      byte_q <= rate_code;
      else if (wr_byte) byte_q <= wdata;
      if (wr_pix)       pix_q  <= wdata;
    end
  end

  assign byte_ratio = {1'b0, byte_q} + (FW+1)'(1);
  assign bit_ratio  = byte_ratio >> 3;

  always_comb begin
    if (bit_ratio == '0)          bit_q = '0;
    else if (bit_ratio > BIT_MAX) bit_q = '1;
    else                          bit_q = BW'(bit_ratio - (FW+1)'(1));
  end

  assign fld[0] = {{(FW-BW){1'b0}}, bit_q};
  assign fld[1] = byte_q;
  assign fld[2] = pix_q;

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    logic [FW-1:0] cnt, act, cnt_n, act_n;
    logic [FW:0]   hi_n;
    logic          term, q;

    assign term  = (cnt == act);
    assign cnt_n = term ? '0 : cnt + 1'b1;
    assign act_n = term ? fld[i] : act;
    assign hi_n  = ({1'b0, act_n} + (FW+1)'(2)) >> 1;

    always_ff @(posedge clk_vco or negedge rst_n) begin
      if (!rst_n) begin
        cnt <= '0;
        act <= '0;
        q   <= 1'b0;
      end else if (!en) begin
        cnt <= fld[i];
        act <= fld[i];
        q   <= 1'b0;
      end else begin
        cnt <= cnt_n;
        act <= act_n;
        q   <= ({1'b0, cnt_n} < hi_n);
      end
    end

    assign dout[i] = (act == '0) ? (clk_vco & run) : q;
  end

  assign byte_field = byte_q;
  assign pix_field  = pix_q;
  assign bit_field  = bit_q;
  assign bit_clk    = dout[0];
  assign byte_clk   = dout[1];
  assign pix_clk    = dout[2];
endmodule

module pll_postdiv_bank_chk #(
  parameter int FW     = 8,
  parameter int RW     = 12,
  parameter int T_SLOW = 125,
  parameter int T_FAST = 600
) (
  input logic          clk_vco,
  input logic          rst_n,
  input logic          en,
  input logic          wr_byte,
  input logic          wr_pix,
  input logic          wr_rate,
  input logic [FW-1:0] wdata,
  input logic [RW-1:0] bit_mhz,
  input logic [FW-1:0] byte_field,
  input logic [FW-1:0] pix_field,
  input logic          bit_clk,
  input logic          byte_clk,
  input logic          pix_clk
);
  p_rate_lo_r4: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (wr_rate && bit_mhz < RW'(T_SLOW)) |=> (byte_field == FW'(63)));

  p_rate_hi_r4: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (wr_rate && bit_mhz >= RW'(T_FAST)) |=> (byte_field == FW'(7)));

  p_wrbyte_r2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (wr_byte && !wr_rate) |=> (byte_field == $past(wdata)));

  p_wrpix_r2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    wr_pix |=> (pix_field == $past(wdata)));

  p_hold_r2: assert property (@(posedge clk_vco) disable iff (!rst_n)
    (!wr_byte && !wr_rate) |=> $stable(byte_field));

  p_off_r9: assert property (@(posedge clk_vco) disable iff (!rst_n)
    !$past(en) |-> (!bit_clk && !byte_clk && !pix_clk));
endmodule

bind pll_postdiv_bank pll_postdiv_bank_chk #(
  .FW(FW), .RW(RW), .T_SLOW(T_SLOW), .T_FAST(T_FAST)
) u_chk (
  .clk_vco(clk_vco), .rst_n(rst_n), .en(en), .wr_byte(wr_byte),
  .wr_pix(wr_pix), .wr_rate(wr_rate), .wdata(wdata), .bit_mhz(bit_mhz),
  .byte_field(byte_field), .pix_field(pix_field), .bit_clk(bit_clk),
  .byte_clk(byte_clk), .pix_clk(pix_clk)
);

// File: tb/pll_postdiv_bank_bench.sv
module pll_postdiv_bank_bench;
  localparam time TCLK = 10ns;

  logic clk_vco = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic wr_byte = 1'b0, wr_pix = 1'b0, wr_rate = 1'b0;
  logic [7:0] wdata = '0;
  logic [11:0] bit_mhz = '0;
  logic [7:0] byte_field, pix_field;
  logic [3:0] bit_field;
  logic bit_clk, byte_clk, pix_clk;
  logic [2:0] outs;
  int n_chk = 0, n_bad = 0, sel = 0;
  logic cur;

  always #(TCLK/2) clk_vco = ~clk_vco;
  assign outs = {pix_clk, byte_clk, bit_clk};

  pll_postdiv_bank u_pll_postdiv_bank (.*);

  task automatic check(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk_vco); #1; cur = outs[sel];
  endtask

  task automatic run_len(output int n);
    logic lv = cur;
    n = 0;
    while (cur == lv && n < 1000) begin n++; step(); end
  endtask

  task automatic sync_rise();
    step();
    while (cur != 1'b0) step();
    while (cur != 1'b1) step();
  endtask

  task automatic measure(input int s, input int eh, input int el, input string tag);
    int h, l;
    sel = s;
    sync_rise();
    run_len(h);
    run_len(l);
    check(h, eh, {tag, " high"});
    check(l, el, {tag, " low"});
  endtask

  task automatic wr(input logic b, input logic p, input logic r, input int d, input int mhz);
    @(negedge clk_vco); #1;
    wr_byte = b; wr_pix = p; wr_rate = r; wdata = 8'(d); bit_mhz = 12'(mhz);
    @(negedge clk_vco); #1;
    wr_byte = 0; wr_pix = 0; wr_rate = 0;
  endtask

  task automatic t_reset();
    check(byte_field, 7, "R3 byte reset");
    check(pix_field, 3, "R3 pix reset");
    check(bit_field, 0, "R3 bit reset");
    check(int'(outs), 0, "R9 outputs low at reset");
  endtask

  task automatic t_basic();
    @(negedge clk_vco); #1; en = 1;
    measure(1, 4, 4, "R1 R6 byte ratio 8");
    measure(2, 2, 2, "R1 R6 pix ratio 4");
  endtask

  task automatic t_odd();
    wr(1, 0, 0, 4, 0);
    check(byte_field, 4, "R2 byte write");
    check(bit_field, 0, "R5 bit from ratio 5");
    repeat (20) @(negedge clk_vco);
    measure(1, 3, 2, "R6 byte ratio 5");
    wr(0, 1, 0, 9, 0);
    check(pix_field, 9, "R2 pix write");
    check(byte_field, 4, "R2 byte holds on pix write");
    repeat (20) @(negedge clk_vco);
    measure(2, 5, 5, "R1 pix ratio 10");
  endtask

  task automatic t_rate();
    int mhz[8] = '{100, 124, 125, 249, 250, 599, 600, 2000};
    int code[8] = '{63, 63, 31, 31, 15, 15, 7, 7};
    int bf[8] = '{7, 7, 3, 3, 1, 1, 0, 0};
    for (int k = 0; k < 8; k++) begin
      wr(0, 0, 1, 0, mhz[k]);
      check(byte_field, code[k], $sformatf("R4 rate %0d MHz", mhz[k]));
      check(bit_field, bf[k], $sformatf("R5 bit field at %0d MHz", mhz[k]));
    end
    wr(1, 0, 1, 200, 300);
    check(byte_field, 15, "R2 rate wins over byte write");
  endtask

  task automatic t_bitdiv();
    wr(0, 0, 1, 0, 100);
    repeat (80) @(negedge clk_vco);
    measure(0, 4, 4, "R5 R1 bit ratio 8");
    measure(1, 32, 32, "R1 byte ratio 64");
  endtask

  task automatic t_clamp();
    wr(1, 0, 0, 255, 0);
    check(bit_field, 15, "R5 clamp ratio 256");
    wr(1, 0, 0, 127, 0);
    check(bit_field, 15, "R5 ratio 128");
    wr(1, 0, 0, 119, 0);
    check(bit_field, 14, "R5 ratio 120");
  endtask

  task automatic t_reload();
    int h, l, h2, l2;
    sel = 2;
    sync_rise();
    step(); step();
    wr_pix = 1; wdata = 8'd2;
    step();
    wr_pix = 0;
    run_len(h); h += 3;
    run_len(l);
    run_len(h2);
    run_len(l2);
    check(h, 5, "R8 old high completes");
    check(l, 5, "R8 old low completes");
    check(h2, 2, "R8 new high");
    check(l2, 1, "R8 new low");
  endtask

  task automatic t_pass();
    int bad = 0;
    wr(1, 0, 0, 0, 0);
    check(bit_field, 0, "R5 bit from ratio 1");
    repeat (300) @(negedge clk_vco);
    for (int k = 0; k < 10; k++) begin
      @(posedge clk_vco); #2;
      if (byte_clk !== 1'b1 || bit_clk !== 1'b1) bad++;
      @(negedge clk_vco); #1;
      if (byte_clk !== 1'b0 || bit_clk !== 1'b0) bad++;
    end
    check(bad, 0, "R7 passthrough mismatches");
  endtask

  task automatic t_enable();
    int hi = 0;
    @(negedge clk_vco); #1; en = 0;
    @(negedge clk_vco);
    for (int k = 0; k < 20; k++) begin
      @(posedge clk_vco); #2; hi += $countones(outs);
      @(negedge clk_vco); #1; hi += $countones(outs);
    end
    check(hi, 0, "R9 outputs low while disabled");
    en = 1;
    @(negedge clk_vco); #1;
    check(pix_clk, 1, "R9 pix high at first enabled edge");
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_vco);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: got 1 expected 0");
    finish_run();
  end

  initial begin
    #(TCLK * 3);
    t_reset();
    @(negedge clk_vco); rst_n = 1;
    t_basic();
    t_odd();
    t_rate();
    t_bitdiv();
    t_clamp();
    t_reload();
    t_pass();
    t_enable();
    finish_run();
  end
endmodule